// File: doc/BRIEF.md
# Interrupt destination resolver

This block takes one interrupt request, described by a destination identifier, an addressing mode, a delivery mode, a vector and a trigger flag, and turns it into a stream of per-CPU injections. It looks at a fixed bank of CPU slots. Each slot reports whether it is present, plus its physical identifier, its logical identifier and its current task priority. From these inputs the block forms a target bitmask.

The delivery mode then decides what happens to that mask. In fixed mode every targeted slot receives the interrupt. In lowest-priority mode a single slot is chosen. Any other mode is discarded and an error pulse is raised.

Injections leave the block one per clock. Each one carries the slot index, the vector and the trigger flag. While injections remain, the block holds busy and ignores new requests. A request is accepted on a rising clock edge where `req_valid` is high and `busy` is low. The slot inputs are sampled at that same edge.

Top module: `irq_dest_router`

## Requirements
- R1: Physical addressing (`req_logical`=0) with destination 8'hFF targets every slot whose present bit is set.
- R2: Physical addressing with any destination other than 8'hFF targets only the lowest-numbered present slot whose physical identifier equals the destination, so at most one slot.
- R3: Logical addressing (`req_logical`=1) with destination 8'h00 targets no slot.
- R4: Logical addressing with a nonzero destination targets every present slot for which (destination AND logical identifier) is nonzero.
- R5: When the target mask is empty, no injection is emitted and `busy` stays low.
- R6: Delivery mode 3'b000 (fixed) emits one injection per cycle for every slot in the mask, in ascending slot order. The first injection appears in the cycle after acceptance, and each carries the request's vector and trigger flag.
- R7: Delivery mode 3'b001 (lowest priority) emits exactly one injection, to the masked slot with the numerically smallest task priority. On a tie, the lowest slot index wins.
- R8: Any delivery mode other than 3'b000 and 3'b001 emits no injection and drives `mode_err` high for the one cycle after acceptance.
- R9: `busy` is high exactly while injections remain, and a request presented while `busy` is high is ignored.
- R10: Synchronous reset clears `busy`, `inj_valid` and `mode_err`, and abandons any injections still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_dest | input | ID_W | Destination identifier |
| req_logical | input | 1 | 0 = physical addressing, 1 = logical addressing |
| req_mode | input | 3 | Delivery mode (000 fixed, 001 lowest priority) |
| req_vector | input | VEC_W | Interrupt vector |
| req_level | input | 1 | Trigger flag (1 = level) |
| slot_present | input | NUM_SLOTS | Per-slot present bits |
| slot_phys_id | input | NUM_SLOTS*ID_W | Physical identifiers, slot i in bits [i*ID_W +: ID_W] |
| slot_logic_id | input | NUM_SLOTS*ID_W | Logical identifiers, same packing |
| slot_prio | input | NUM_SLOTS*PRIO_W | Task priorities, same packing |
| busy | output | 1 | Injections still pending |
| inj_valid | output | 1 | Injection present this cycle |
| inj_slot | output | SLOT_W | Target slot index |
| inj_vector | output | VEC_W | Vector of the injection |
| inj_level | output | 1 | Trigger flag of the injection |
| mode_err | output | 1 | One-cycle pulse for an unsupported delivery mode |

## Verification
The slot bank is set up with two present slots that share a physical identifier, one absent slot whose identifiers would otherwise match, and a logical identifier that spans two bits. With this setup, broadcast, first-match and no-match physical requests each produce a different mask. Logical requests with overlapping destinations show whether the AND rule is applied and whether absent slots are excluded. Lowest-priority requests are arranged so that one has a unique minimum and another a tie, which separates lowest-index tie breaking from other orderings. Requests presented during a burst, and a reset in the middle of a burst, show whether the sequencer really drops work it must not do.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        DLV_FIXED  = 3'b000,
        DLV_LOWEST = 3'b001
    } dlv_mode_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_ALL,
        ACT_ONE,
        ACT_BAD
    } dlv_action_e;

    function automatic dlv_action_e classify_mode(input logic [MODE_W-1:0] mode);
        case (mode)
            DLV_FIXED:  return ACT_ALL;
            DLV_LOWEST: return ACT_ONE;
            default:    return ACT_BAD;
        endcase
    endfunction

endpackage

// File: rtl/irq_dest_mask.sv
module irq_dest_mask #(
    parameter int NUM_SLOTS = 32,
    parameter int ID_W      = 8
) (
    input  logic [ID_W-1:0]           dest,
    input  logic                      logical,
    input  logic [NUM_SLOTS-1:0]      present,
    input  logic [NUM_SLOTS*ID_W-1:0] phys_id,
    input  logic [NUM_SLOTS*ID_W-1:0] logic_id,
    output logic [NUM_SLOTS-1:0]      mask
);
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic [NUM_SLOTS-1:0] phys_hit;
    logic [NUM_SLOTS-1:0] log_hit;
    logic [NUM_SLOTS-1:0] phys_first;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign phys_hit[s] = present[s] && (phys_id[s*ID_W +: ID_W] == dest);
        assign log_hit[s]  = present[s] && ((logic_id[s*ID_W +: ID_W] & dest) != '0);
    end

    // isolate the lowest set bit: first matching slot in ascending order
    assign phys_first = phys_hit & (~phys_hit + NUM_SLOTS'(1));

    always_comb begin
        if (logical) begin
            mask = (dest == '0) ? '0 : log_hit;
        end else if (dest == BCAST) begin
            mask = present;
        end else begin
            mask = phys_first;
        end
    end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int NUM_SLOTS = 32,
    parameter int PRIO_W    = 8
) (
    input  logic [NUM_SLOTS-1:0]        cand,
    input  logic [NUM_SLOTS*PRIO_W-1:0] prio,
    output logic [NUM_SLOTS-1:0]        pick
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic [SLOT_W-1:0] best_idx;
    logic [PRIO_W-1:0] best_prio;
    logic              found;

    always_comb begin
        best_idx  = '0;
        best_prio = '1;
        found     = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            // strict compare keeps the lower index on a tie
            if (cand[s] && (!found || prio[s*PRIO_W +: PRIO_W] < best_prio)) begin
                best_idx  = SLOT_W'(s);
                best_prio = prio[s*PRIO_W +: PRIO_W];
                found     = 1'b1;
            end
        end
        pick = '0;
        if (found) pick[best_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_inject_seq.sv
module irq_inject_seq
    import irq_route_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int VEC_W     = 8,
    parameter int SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 accept,
    input  dlv_action_e          action,
    input  logic [NUM_SLOTS-1:0] all_mask,
    input  logic [NUM_SLOTS-1:0] one_mask,
    input  logic [VEC_W-1:0]     vector,
    input  logic                 level,
    output logic                 busy,
    output logic                 inj_valid,
    output logic [SLOT_W-1:0]    inj_slot,
    output logic [VEC_W-1:0]     inj_vector,
    output logic                 inj_level,
    output logic                 mode_err
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] pend;
        logic [VEC_W-1:0]     vec;
        logic                 lvl;
        logic                 err;
    } seq_state_t;

    seq_state_t st_q, st_d;
    logic [NUM_SLOTS-1:0] low_bit;
    logic [SLOT_W-1:0]    low_idx;

    assign low_bit = st_q.pend & (~st_q.pend + NUM_SLOTS'(1));

    always_comb begin
        low_idx = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (low_bit[s]) low_idx = SLOT_W'(s);
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.err  = 1'b0;
        st_d.pend = st_q.pend & ~low_bit;
        if (accept) begin
            st_d.vec = vector;
            st_d.lvl = level;
            case (action)
                ACT_ALL: st_d.pend = all_mask;
                ACT_ONE: st_d.pend = one_mask;
                ACT_BAD: begin
                    st_d.pend = '0;
                    st_d.err  = 1'b1;
                end
                default: st_d.pend = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = |st_q.pend;
    assign inj_valid  = |low_bit;
    assign inj_slot   = low_idx;
    assign inj_vector = st_q.vec;
    assign inj_level  = st_q.lvl;
    assign mode_err   = st_q.err;
endmodule

// File: rtl/irq_dest_router.sv
module irq_dest_router
    import irq_route_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int ID_W      = 8,
    parameter int PRIO_W    = 8,
    parameter int VEC_W     = 8,
    localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic [ID_W-1:0]             req_dest,
    input  logic                        req_logical,
    input  logic [MODE_W-1:0]           req_mode,
    input  logic [VEC_W-1:0]            req_vector,
    input  logic                        req_level,
    input  logic [NUM_SLOTS-1:0]        slot_present,
    input  logic [NUM_SLOTS*ID_W-1:0]   slot_phys_id,
    input  logic [NUM_SLOTS*ID_W-1:0]   slot_logic_id,
    input  logic [NUM_SLOTS*PRIO_W-1:0] slot_prio,
    output logic                        busy,
    output logic                        inj_valid,
    output logic [SLOT_W-1:0]           inj_slot,
    output logic [VEC_W-1:0]            inj_vector,
    output logic                        inj_level,
    output logic                        mode_err
);
    logic [NUM_SLOTS-1:0] tgt_mask;
    logic [NUM_SLOTS-1:0] tgt_pick;
    logic                 accept;
    dlv_action_e          action;

    assign accept = req_valid && !busy;
    assign action = classify_mode(req_mode);

    irq_dest_mask #(.NUM_SLOTS(NUM_SLOTS), .ID_W(ID_W)) u_mask (
        .dest     (req_dest),
        .logical  (req_logical),
        .present  (slot_present),
        .phys_id  (slot_phys_id),
        .logic_id (slot_logic_id),
        .mask     (tgt_mask)
    );

    irq_prio_pick #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_pick (
        .cand (tgt_mask),
        .prio (slot_prio),
        .pick (tgt_pick)
    );

    irq_inject_seq #(.NUM_SLOTS(NUM_SLOTS), .VEC_W(VEC_W), .SLOT_W(SLOT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .action     (action),
        .all_mask   (tgt_mask),
        .one_mask   (tgt_pick),
        .vector     (req_vector),
        .level      (req_level),
        .busy       (busy),
        .inj_valid  (inj_valid),
        .inj_slot   (inj_slot),
        .inj_vector (inj_vector),
        .inj_level  (inj_level),
        .mode_err   (mode_err)
    );
endmodule

// File: rtl/irq_dest_router_chk.sv
module irq_dest_router_chk #(
    parameter int SLOT_W = 5,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              inj_valid,
    input logic [SLOT_W-1:0] inj_slot,
    input logic [VEC_W-1:0]  inj_vector,
    input logic              inj_level,
    input logic              mode_err
);
    // R6: back-to-back injections belong to one burst and rise in slot order
    p_ascending_r6: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && $past(inj_valid) && !$past(rst)) |-> (inj_slot > $past(inj_slot)));

    // R6: a burst keeps one vector and one trigger flag
    p_payload_stable_r6: assert property (@(posedge clk) disable iff (rst)
        (inj_valid && $past(inj_valid) && !$past(rst)) |-> ($stable(inj_vector) && $stable(inj_level)));

    // R8: an unsupported mode produces no injection alongside its error pulse
    p_err_no_inj_r8: assert property (@(posedge clk) disable iff (rst)
        mode_err |-> !inj_valid);

    // R9: once busy falls, the injection stream has ended
    p_drop_clean_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(busy) && !$past(rst)) |-> !inj_valid);

    // R10: the cycle after reset shows an idle block
    p_reset_idle_r10: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !inj_valid && !mode_err));
endmodule

bind irq_dest_router irq_dest_router_chk #(.SLOT_W(SLOT_W), .VEC_W(VEC_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .inj_valid  (inj_valid),
    .inj_slot   (inj_slot),
    .inj_vector (inj_vector),
    .inj_level  (inj_level),
    .mode_err   (mode_err)
);

// File: tb/irq_dest_router_tb.sv
module irq_dest_router_tb;
    localparam int N = 8;
    localparam int SW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [7:0] req_dest = '0;
    logic req_logical = 1'b0;
    logic [2:0] req_mode = '0;
    logic [7:0] req_vector = '0;
    logic req_level = 1'b0;
    logic [N-1:0] slot_present;
    logic [N*8-1:0] slot_phys_id, slot_logic_id, slot_prio;
    logic busy, inj_valid, inj_level, mode_err;
    logic [SW-1:0] inj_slot;
    logic [7:0] inj_vector;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    irq_dest_router #(.NUM_SLOTS(N)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_dest(req_dest),
        .req_logical(req_logical), .req_mode(req_mode), .req_vector(req_vector),
        .req_level(req_level), .slot_present(slot_present), .slot_phys_id(slot_phys_id),
        .slot_logic_id(slot_logic_id), .slot_prio(slot_prio), .busy(busy),
        .inj_valid(inj_valid), .inj_slot(inj_slot), .inj_vector(inj_vector),
        .inj_level(inj_level), .mode_err(mode_err)
    );

    // slot 3 absent; slots 2 and 5 share physical id 8'h22; slot 6 logical id spans two bits
    // priorities: slots 4 and 6 tie at 8'h10
    initial begin
        slot_present  = 8'b1111_0111;
        slot_phys_id  = {8'h27, 8'h26, 8'h22, 8'h24, 8'h40, 8'h22, 8'h21, 8'h20};
        slot_logic_id = {8'h80, 8'h03, 8'h20, 8'h10, 8'h08, 8'h04, 8'h02, 8'h01};
        slot_prio     = {8'h90, 8'h10, 8'h70, 8'h10, 8'h00, 8'h30, 8'h30, 8'h50};
    end

    typedef struct packed {
        logic [7:0] dest;
        logic       lg;
        logic [2:0] mode;
        logic [7:0] vec;
        logic       lvl;
        logic [7:0] exp_mask;
        logic       exp_err;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 1'b0, 3'd0, 8'h31, 1'b0, 8'hF7, 1'b0},
        '{8'h22, 1'b0, 3'd0, 8'h32, 1'b1, 8'h04, 1'b0},
        '{8'h40, 1'b0, 3'd0, 8'h33, 1'b0, 8'h00, 1'b0},
        '{8'h99, 1'b0, 3'd0, 8'h34, 1'b0, 8'h00, 1'b0},
        '{8'h00, 1'b1, 3'd0, 8'h35, 1'b1, 8'h00, 1'b0},
        '{8'h05, 1'b1, 3'd0, 8'h36, 1'b1, 8'h45, 1'b0},
        '{8'h06, 1'b1, 3'd1, 8'h37, 1'b0, 8'h40, 1'b0},
        '{8'hFF, 1'b0, 3'd1, 8'h38, 1'b1, 8'h10, 1'b0},
        '{8'h14, 1'b1, 3'd1, 8'h39, 1'b0, 8'h10, 1'b0},
        '{8'h00, 1'b1, 3'd1, 8'h3A, 1'b0, 8'h00, 1'b0},
        '{8'hFF, 1'b0, 3'd2, 8'h3B, 1'b0, 8'h00, 1'b1},
        '{8'h05, 1'b1, 3'd7, 8'h3C, 1'b1, 8'h00, 1'b1},
        '{8'h21, 1'b0, 3'd1, 8'h3D, 1'b1, 8'h02, 1'b0}
    };

    function automatic string tag_of(vec_t v);
        if (v.mode > 3'd1) return "R8";
        if (v.lg && v.dest == 8'h00) return "R3";
        if (v.exp_mask == 8'h00) return "R5";
        if (v.mode == 3'd1) return "R7";
        if (v.lg) return "R4";
        if (v.dest == 8'hFF) return "R1";
        return "R2";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic issue(input vec_t v);
        @(negedge clk);
        req_dest = v.dest; req_logical = v.lg; req_mode = v.mode;
        req_vector = v.vec; req_level = v.lvl; req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    // samples from the first negedge after acceptance until busy drops
    task automatic collect(input vec_t v, input string tag, output logic [7:0] seen,
                           output bit err_seen, output bit order_ok, output bit pay_ok);
        int last;
        seen = '0; order_ok = 1'b1; pay_ok = 1'b1; last = -1;
        @(negedge clk);
        err_seen = mode_err;
        for (int c = 0; c < 20; c++) begin
            if (inj_valid) begin
                if (int'(inj_slot) <= last) order_ok = 1'b0;
                if (inj_vector != v.vec || inj_level != v.lvl) pay_ok = 1'b0;
                last = int'(inj_slot);
                seen[inj_slot] = 1'b1;
            end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] seen;
        bit e, o, p;
        int cnt;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        chk(!busy && !inj_valid && !mode_err, "R10", "idle under reset",
            {busy, inj_valid, mode_err}, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i]);
            collect(TBL[i], tag_of(TBL[i]), seen, e, o, p);
            chk(seen == TBL[i].exp_mask, tag_of(TBL[i]), "target mask", seen, TBL[i].exp_mask);
            chk(e == TBL[i].exp_err, "R8", "mode_err pulse", e, TBL[i].exp_err);
            chk(o && p, "R6", "order and payload", {o, p}, 3);
        end

        // R8: error pulse lasts one cycle
        issue(TBL[10]);
        @(negedge clk);
        @(negedge clk);
        chk(!mode_err, "R8", "error cleared after one cycle", mode_err, 0);

        // R6: first injection lands in the cycle after acceptance
        issue(TBL[0]);
        @(negedge clk);
        chk(inj_valid && inj_slot == 3'd0, "R6", "first injection timing", inj_slot, 0);
        while (busy) @(negedge clk);

        // R9: requests during a burst are ignored
        issue('{8'hFF, 1'b0, 3'd0, 8'h61, 1'b0, 8'hF7, 1'b0});
        cnt = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            req_valid = (c < 3);
            req_dest = 8'h01; req_logical = 1'b1; req_mode = 3'd0; req_vector = 8'h77;
            if (inj_valid) begin
                cnt++;
                chk(inj_vector == 8'h61, "R9", "no foreign vector in burst", inj_vector, 8'h61);
            end
            if (!busy) break;
        end
        req_valid = 1'b0;
        chk(cnt == 7, "R9", "burst length unchanged", cnt, 7);
        repeat (3) @(negedge clk);
        chk(!inj_valid && !busy, "R9", "ignored request not replayed", {inj_valid, busy}, 0);

        // R10: reset in mid-burst abandons pending work
        issue(TBL[0]);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !inj_valid, "R10", "mid-burst reset", {busy, inj_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !inj_valid, "R10", "stays idle after reset", {busy, inj_valid}, 0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule